// File: doc/BRIEF.md
# Buffered SPI Transaction Host

This block is an SPI host that runs a whole multi-byte transaction without software touching the shift path. Software first loads a command buffer, one byte per register address. It then writes one control word. That word gives the byte count, a coded clock speed, the clock polarity/phase mode and the target device, and it carries a start bit. The engine clocks every command byte out on a single data line, MSB first. It captures one received byte per byte sent into a separate response buffer, which software reads back after completion.

Completion sets a sticky event flag. Software clears the flag by writing a one to it. A mask bit gates the flag onto a level interrupt output. A force-enable bit can hold the selected chip select active between transactions, so that several transactions form one framed exchange on the target.

All buffers and registers share one simple register port. A read returns its data one cycle after the request.

Top module: `spi_txn_host`

## Requirements
- R1: After reset, the control word at 0x400 reads 0, the event word at 0x420 reads 0, the mask word at 0x424 reads 0x100 (bit 8 set, completion masked), all chip selects are high and the interrupt is low.
- R2: Writing 1 to control bit 0 while idle starts a transaction. The engine sends byte i from address 0x000+i (low 8 bits of the write data), MSB first. Control bit 0 reads 1 while the transaction runs and 0 once it ends.
- R3: The byte received while sending byte i is readable in the low 8 bits at address 0x200+i. The first bit received is the MSB.
- R4: With control bit 2 at 0, SCLK idles low. With control bit 2 at 1, SCLK idles high. In both modes every bit is a low half followed by a high half: MOSI changes only with a falling SCLK edge and MISO is sampled on each rising edge.
- R5: The speed code in control bits 7:5 sets the SCLK half-period in system clocks: 2 gives 1, 3 gives 2, 4 gives 2, 5 gives 3, 6 gives 3, 7 gives 16. Codes 0 and 1 use the half-period of code 2.
- R6: Event bit 8 sets when a transaction completes. Writing 1 to it clears it, and writing 0 leaves it set.
- R7: The interrupt output is high exactly when event bit 8 is set and mask bit 8 is 0.
- R8: Device field bits 27:25 with a value 0..6 drives cs_n[value] low during a transaction. The value 7 selects no line. Never more than one chip select is low.
- R9: Control bit 4 set holds the selected chip select low while idle, including after a transaction ends. Clearing it releases the line.
- R10: While a transaction runs, writes to the command buffer are dropped, and control writes change only bit 4. Length, speed, mode, device and start are kept.
- R11: A length of 0 (bits 16:8) completes without any SCLK edge and sets event bit 8.
- R12: A length above 320 runs exactly 320 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read request |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | Host-to-target serial data |
| miso | input | 1 | Target-to-host serial data |
| cs_n | output | 7 | Active-low chip selects |
| irq | output | 1 | Level completion interrupt |

## Verification
The bench builds the block with its defaults: 320-byte buffers and seven chip selects. The full buffer depth is therefore reached, and a length of 400 exercises the clamp and the last buffer address 319. With the default divider table, the fastest code toggles SCLK every system clock and the slowest holds each half for 16 clocks. The bench measures both extremes, a middle code and an unused code. Both SPI modes run against a target model that shifts a known reply pattern.

// File: rtl/spi_txn_pkg.sv
package spi_txn_pkg;

    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int LEN_W   = 9;
    localparam int SEL_W   = 3;
    localparam int DIV_W   = 5;

    localparam logic [ADDR_W-1:0] A_CMD_BASE = 12'h000;
    localparam logic [ADDR_W-1:0] A_RSP_BASE = 12'h200;
    localparam logic [ADDR_W-1:0] A_CTL      = 12'h400;
    localparam logic [ADDR_W-1:0] A_EVT      = 12'h420;
    localparam logic [ADDR_W-1:0] A_MSK      = 12'h424;

    localparam int B_GO    = 0;
    localparam int B_MODE  = 2;
    localparam int B_FORCE = 4;
    localparam int B_SPD   = 5;
    localparam int B_LEN   = 8;
    localparam int B_DEV   = 25;
    localparam int B_DONE  = 8;

    localparam logic [DIV_W-1:0] HALF_C2 = 5'd1;
    localparam logic [DIV_W-1:0] HALF_C3 = 5'd2;
    localparam logic [DIV_W-1:0] HALF_C4 = 5'd2;
    localparam logic [DIV_W-1:0] HALF_C5 = 5'd3;
    localparam logic [DIV_W-1:0] HALF_C6 = 5'd3;
    localparam logic [DIV_W-1:0] HALF_C7 = 5'd16;

    typedef struct packed {
        logic [SEL_W-1:0] dev;
        logic [LEN_W-1:0] len;
        logic [2:0]       speed;
        logic             force_ce;
        logic             mode3;
    } ctl_t;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_SHIFT,
        ENG_FINISH
    } eng_state_t;

    function automatic logic [DIV_W-1:0] half_div(input logic [2:0] code);
        logic [DIV_W-1:0] d;
        case (code)
            3'd3:    d = HALF_C3;
            3'd4:    d = HALF_C4;
            3'd5:    d = HALF_C5;
            3'd6:    d = HALF_C6;
            3'd7:    d = HALF_C7;
            default: d = HALF_C2;
        endcase
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctl(input ctl_t c, input logic running);
        logic [DATA_W-1:0] w;
        w = '0;
        w[B_GO]               = running;
        w[B_MODE]             = c.mode3;
        w[B_FORCE]            = c.force_ce;
        w[B_SPD +: 3]         = c.speed;
        w[B_LEN +: LEN_W]     = c.len;
        w[B_DEV +: SEL_W]     = c.dev;
        return w;
    endfunction

endpackage

// File: rtl/spi_txn_ram.sv
module spi_txn_ram #(
    parameter int DEPTH = 320,
    parameter int AW    = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && waddr <= LAST) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = (raddr <= LAST) ? mem[raddr] : 8'h00;
    end
endmodule

// File: rtl/spi_txn_engine.sv
module spi_txn_engine
    import spi_txn_pkg::*;
#(
    parameter int BUF_BYTES = 320
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] len_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [7:0]       cmd_byte,
    input  logic             miso,
    output logic [LEN_W-1:0] idx,
    output logic             busy,
    output logic             shifting,
    output logic             sclk_hi,
    output logic             mosi,
    output logic             rsp_we,
    output logic [7:0]       rsp_byte,
    output logic             done
);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(BUF_BYTES);

    eng_state_t       state;
    logic [LEN_W-1:0] len_q;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt;
    logic [2:0]       bitn;
    logic             phase;
    logic [7:0]       rx;
    logic [LEN_W-1:0] eff_len;
    logic             tick;

    always_comb begin
        eff_len = (len_i > MAX_LEN) ? MAX_LEN : len_i;
        tick    = (state == ENG_SHIFT) && (cnt == div_q - 5'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ENG_IDLE;
            len_q <= '0;
            div_q <= 5'd1;
            cnt   <= '0;
            bitn  <= '0;
            phase <= 1'b0;
            idx   <= '0;
            rx    <= '0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (start) begin
                        len_q <= eff_len;
                        div_q <= div_i;
                        cnt   <= '0;
                        bitn  <= '0;
                        phase <= 1'b0;
                        idx   <= '0;
                        state <= (eff_len == '0) ? ENG_FINISH : ENG_SHIFT;
                    end
                end
                ENG_SHIFT: begin
                    if (tick) begin
                        cnt   <= '0;
                        phase <= ~phase;
                        if (!phase) begin
                            rx <= {rx[6:0], miso};
                        end else if (bitn == 3'd7) begin
                            bitn <= '0;
                            if (idx == len_q - 1'b1) begin
                                state <= ENG_FINISH;
                            end else begin
                                idx <= idx + 1'b1;
                            end
                        end else begin
                            bitn <= bitn + 3'd1;
                        end
                    end else begin
                        cnt <= cnt + 5'd1;
                    end
                end
                ENG_FINISH: state <= ENG_IDLE;
                default:    state <= ENG_IDLE;
            endcase
        end
    end

    always_comb begin
        busy     = (state != ENG_IDLE);
        shifting = (state == ENG_SHIFT);
        done     = (state == ENG_FINISH);
        sclk_hi  = phase;
        mosi     = shifting ? cmd_byte[3'd7 - bitn] : 1'b0;
        rsp_we   = tick && phase && (bitn == 3'd7);
        rsp_byte = rx;
    end
endmodule

// File: rtl/spi_txn_csdec.sv
module spi_txn_csdec #(
    parameter int NUM_CS = 7,
    parameter int SEL_W  = 3
) (
    input  logic              en,
    input  logic [SEL_W-1:0]  sel,
    output logic [NUM_CS-1:0] cs_n
);
    for (genvar i = 0; i < NUM_CS; i++) begin : g_line
        assign cs_n[i] = ~(en && (sel == SEL_W'(i)));
    end
endmodule

// File: rtl/spi_txn_host.sv
module spi_txn_host
    import spi_txn_pkg::*;
#(
    parameter int BUF_BYTES = 320,
    parameter int NUM_CS    = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] CMD_END = A_CMD_BASE + ADDR_W'(BUF_BYTES);
    localparam logic [ADDR_W-1:0] RSP_END = A_RSP_BASE + ADDR_W'(BUF_BYTES);

    ctl_t             ctl;
    logic             evt_done;
    logic             msk_done;
    logic             wr;
    logic             rd;
    logic             in_cmd;
    logic             in_rsp;
    logic             start;
    logic [ADDR_W-1:0] rsp_off;

    logic             eng_busy;
    logic             eng_shift;
    logic             eng_hi;
    logic             eng_mosi;
    logic             eng_done;
    logic             rsp_we;
    logic [7:0]       rsp_wbyte;
    logic [LEN_W-1:0] eng_idx;
    logic [7:0]       cmd_rbyte;
    logic [7:0]       rsp_rbyte;
    logic             ctl_mode3;
    logic [LEN_W-1:0] ctl_len;

    always_comb begin
        wr      = reg_en && reg_we;
        rd      = reg_en && !reg_we;
        in_cmd  = (reg_addr < CMD_END);
        in_rsp  = (reg_addr >= A_RSP_BASE) && (reg_addr < RSP_END);
        rsp_off = reg_addr - A_RSP_BASE;
        start   = wr && (reg_addr == A_CTL) && !eng_busy && reg_wdata[B_GO];
        ctl_mode3 = ctl.mode3;
        ctl_len   = ctl.len;
    end

    spi_txn_ram #(.DEPTH(BUF_BYTES), .AW(LEN_W)) u_cmd_ram (
        .clk   (clk),
        .we    (wr && in_cmd && !eng_busy),
        .waddr (reg_addr[LEN_W-1:0]),
        .wdata (reg_wdata[7:0]),
        .raddr (eng_idx),
        .rdata (cmd_rbyte)
    );

    spi_txn_ram #(.DEPTH(BUF_BYTES), .AW(LEN_W)) u_rsp_ram (
        .clk   (clk),
        .we    (rsp_we),
        .waddr (eng_idx),
        .wdata (rsp_wbyte),
        .raddr (rsp_off[LEN_W-1:0]),
        .rdata (rsp_rbyte)
    );

    spi_txn_engine #(.BUF_BYTES(BUF_BYTES)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .len_i    (reg_wdata[B_LEN +: LEN_W]),
        .div_i    (half_div(reg_wdata[B_SPD +: 3])),
        .cmd_byte (cmd_rbyte),
        .miso     (miso),
        .idx      (eng_idx),
        .busy     (eng_busy),
        .shifting (eng_shift),
        .sclk_hi  (eng_hi),
        .mosi     (eng_mosi),
        .rsp_we   (rsp_we),
        .rsp_byte (rsp_wbyte),
        .done     (eng_done)
    );

    spi_txn_csdec #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_csdec (
        .en   (eng_busy || ctl.force_ce),
        .sel  (ctl.dev),
        .cs_n (cs_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (wr && reg_addr == A_CTL) begin
            ctl.force_ce <= reg_wdata[B_FORCE];
            if (!eng_busy) begin
                ctl.mode3 <= reg_wdata[B_MODE];
                ctl.speed <= reg_wdata[B_SPD +: 3];
                ctl.len   <= reg_wdata[B_LEN +: LEN_W];
                ctl.dev   <= reg_wdata[B_DEV +: SEL_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_done <= 1'b0;
            msk_done <= 1'b1;
        end else begin
            if (eng_done) begin
                evt_done <= 1'b1;
            end else if (wr && reg_addr == A_EVT && reg_wdata[B_DONE]) begin
                evt_done <= 1'b0;
            end
            if (wr && reg_addr == A_MSK) begin
                msk_done <= reg_wdata[B_DONE];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (rd) begin
            if (in_rsp) begin
                reg_rdata <= {24'h0, rsp_rbyte};
            end else if (reg_addr == A_CTL) begin
                reg_rdata <= pack_ctl(ctl, eng_busy);
            end else if (reg_addr == A_EVT) begin
                reg_rdata <= 32'(evt_done) << B_DONE;
            end else if (reg_addr == A_MSK) begin
                reg_rdata <= 32'(msk_done) << B_DONE;
            end else begin
                reg_rdata <= '0;
            end
        end
    end

    always_comb begin
        sclk = eng_shift ? eng_hi : ctl.mode3;
        mosi = eng_mosi;
        irq  = evt_done && !msk_done;
    end
endmodule

// File: rtl/spi_txn_host_chk.sv
module spi_txn_host_chk #(
    parameter int NUM_CS = 7
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CS-1:0] cs_n,
    input logic              sclk,
    input logic              mosi,
    input logic              busy,
    input logic              mode3,
    input logic [8:0]        len_field,
    input logic              evt_done,
    input logic              msk_done,
    input logic              irq
);
    assert_cs_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sclk == mode3));

    assert_mosi_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && $rose(sclk)) |-> $stable(mosi));

    assert_len_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(len_field));

    assert_done_event_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> evt_done);

    assert_irq_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($rose(evt_done) || $fell(msk_done)));
endmodule

bind spi_txn_host spi_txn_host_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .mosi      (mosi),
    .busy      (eng_busy),
    .mode3     (ctl_mode3),
    .len_field (ctl_len),
    .evt_done  (evt_done),
    .msk_done  (msk_done),
    .irq       (irq)
);

// File: tb/spi_txn_host_tb.sv
module spi_txn_host_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCS = 7;
    localparam int BUFB = 320;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sclk;
    logic        mosi;
    logic        miso;
    logic [NCS-1:0] cs_n;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int rises = 0;
    int base = 0;
    int cs_low = 0;
    logic [7:0] cap [BUFB];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_txn_host u_dut (
        .clk(clk), .rst(rst), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n), .irq(irq)
    );

    function automatic logic [7:0] rep(input int i);
        return 8'((i * 29 + 17) ^ (i >> 3));
    endfunction

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'(i * 13 + seed * 71 + 5);
    endfunction

    function automatic logic [31:0] ctlw(input int mode3, input int force_ce, input int spd,
                                         input int len, input int dev, input int go);
        return (32'(dev) << 25) | (32'(len) << 8) | (32'(spd) << 5) |
               (32'(force_ce) << 4) | (32'(mode3) << 2) | 32'(go);
    endfunction

    // target model: reply bit for position p is rep(p/8) MSB first
    int bpos;
    always_comb begin
        bpos = rises - base;
        miso = (bpos >= 0 && bpos < BUFB * 8) ? rep(bpos / 8)[7 - (bpos % 8)] : 1'b0;
    end

    always @(posedge sclk) begin
        int p;
        p = rises - base;
        if (cs_n != '1 && p >= 0 && p < BUFB * 8) cap[p / 8][7 - (p % 8)] = mosi;
        rises = rises + 1;
    end

    always @(posedge clk) if (cs_n != '1) cs_low = cs_low + 1;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(posedge clk); #1;
        d = reg_rdata;
        reg_en = 1'b0;
    endtask

    task automatic wait_done(input bit clear);
        logic [31:0] d;
        d = '0;
        for (int k = 0; k < 20000 && !d[8]; k++) rd(12'h420, d);
        chk(d[8], "R6 event set at completion", d, 32'h100);
        if (clear) wr(12'h420, 32'h100);
    endtask

    task automatic fill(input int seed, input int n);
        for (int i = 0; i < n; i++) wr(12'(i), 32'(pat(seed, i)));
    endtask

    task automatic start_txn(input int mode3, input int force_ce, input int spd, input int len, input int dev);
        wr(12'h400, ctlw(mode3, force_ce, spd, len, dev, 0));
        base = rises;
        wr(12'h400, ctlw(mode3, force_ce, spd, len, dev, 1));
    endtask

    task automatic check_data(input int seed, input int n, input string tag);
        logic [31:0] d;
        for (int i = 0; i < n; i++) begin
            chk(cap[i] == pat(seed, i), {tag, " R2 mosi byte"}, 32'(cap[i]), 32'(pat(seed, i)));
            rd(12'h200 + 12'(i), d);
            chk(d == 32'(rep(i)), {tag, " R3 response byte"}, d, 32'(rep(i)));
        end
        chk(rises - base == n * 8, {tag, " R2 sclk rises"}, 32'(rises - base), 32'(n * 8));
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(12'h400, d); chk(d == 0, "R1 control reset", d, 0);
        rd(12'h420, d); chk(d == 0, "R1 event reset", d, 0);
        rd(12'h424, d); chk(d == 32'h100, "R1 mask reset", d, 32'h100);
        chk(cs_n == '1, "R1 chip selects idle", 32'(cs_n), 32'h7f);
        chk(irq == 0 && sclk == 0, "R1 irq and sclk low", {30'b0, irq, sclk}, 0);
    endtask

    task automatic t_mode0();
        logic [31:0] d;
        fill(1, 4);
        start_txn(0, 0, 2, 4, 1);
        rd(12'h400, d); chk(d[0] == 1'b1, "R2 go reads 1 while busy", d, 32'h1);
        @(posedge sclk); #1;
        chk(cs_n == 7'b1111101, "R8 dev 1 selected", 32'(cs_n), 32'h7d);
        wait_done(1);
        check_data(1, 4, "mode0");
        rd(12'h400, d); chk(d[0] == 1'b0, "R2 go clears at end", d, 0);
        chk(sclk == 0 && cs_n == '1, "R4 mode0 idle low, cs released", {30'b0, sclk, &cs_n}, 1);
    endtask

    task automatic t_mode3();
        fill(2, 3);
        wr(12'h400, ctlw(1, 0, 3, 3, 5, 0));
        #1 chk(sclk == 1, "R4 mode3 idles high", 32'(sclk), 1);
        base = rises;
        wr(12'h400, ctlw(1, 0, 3, 3, 5, 1));
        @(posedge sclk); #1;
        chk(cs_n == 7'b1011111, "R8 dev 5 selected", 32'(cs_n), 32'h5f);
        wait_done(1);
        check_data(2, 3, "mode3");
        chk(sclk == 1, "R4 mode3 high after txn", 32'(sclk), 1);
        wr(12'h400, ctlw(0, 0, 2, 0, 0, 0));
    endtask

    task automatic t_div(input int code, input int exp);
        int n;
        fill(3, 1);
        start_txn(0, 0, code, 1, 0);
        @(posedge sclk);
        n = 0;
        while (sclk) begin @(posedge clk); #1; n++; end
        chk(n == exp, $sformatf("R5 half period code %0d", code), 32'(n), 32'(exp));
        wait_done(1);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        start_txn(0, 0, 2, 1, 0);
        wait_done(0);
        #1 chk(irq == 0, "R7 masked irq low", 32'(irq), 0);
        wr(12'h424, 32'h0);
        #1 chk(irq == 1, "R7 unmasked irq high", 32'(irq), 1);
        wr(12'h420, 32'h0);
        rd(12'h420, d); chk(d == 32'h100, "R6 write 0 keeps event", d, 32'h100);
        wr(12'h420, 32'h100);
        rd(12'h420, d); chk(d == 0, "R6 write 1 clears event", d, 0);
        chk(irq == 0, "R7 irq low after clear", 32'(irq), 0);
        wr(12'h424, 32'h100);
    endtask

    task automatic t_len0();
        start_txn(0, 0, 2, 0, 0);
        wait_done(1);
        chk(rises == base, "R11 zero length no sclk", 32'(rises - base), 0);
    endtask

    task automatic t_force();
        wr(12'h400, ctlw(0, 1, 2, 0, 3, 0));
        #1 chk(cs_n == 7'b1110111, "R9 forced cs low idle", 32'(cs_n), 32'h77);
        fill(4, 2);
        start_txn(0, 1, 2, 2, 3);
        wait_done(1);
        chk(cs_n == 7'b1110111, "R9 cs held after txn", 32'(cs_n), 32'h77);
        check_data(4, 2, "force");
        wr(12'h400, ctlw(0, 0, 2, 0, 3, 0));
        #1 chk(cs_n == '1, "R9 cs released", 32'(cs_n), 32'h7f);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] d;
        wr(12'h000, 32'h3C); wr(12'h001, 32'h99);
        start_txn(0, 0, 7, 2, 0);
        wr(12'h000, 32'hFF);
        wr(12'h400, ctlw(1, 0, 2, 5, 4, 1));
        rd(12'h400, d);
        chk(d[16:8] == 9'd2 && d[27:25] == 3'd0 && d[2] == 0 && d[0] == 1,
            "R10 control kept while busy", d, ctlw(0, 0, 7, 2, 0, 1));
        wait_done(1);
        chk(rises - base == 16, "R10 length unchanged", 32'(rises - base), 16);
        start_txn(0, 0, 2, 1, 0);
        wait_done(1);
        chk(cap[0] == 8'h3C, "R10 busy buffer write dropped", 32'(cap[0]), 32'h3C);
    endtask

    task automatic t_dev7();
        cs_low = 0;
        start_txn(0, 0, 2, 2, 7);
        wait_done(1);
        chk(cs_low == 0, "R8 device 7 selects none", 32'(cs_low), 0);
    endtask

    task automatic t_clamp();
        logic [31:0] d;
        fill(5, BUFB);
        start_txn(0, 0, 2, 400, 0);
        wait_done(1);
        chk(rises - base == BUFB * 8, "R12 clamp to 320 bytes", 32'(rises - base), 32'(BUFB * 8));
        chk(cap[BUFB-1] == pat(5, BUFB-1), "R12 last mosi byte", 32'(cap[BUFB-1]), 32'(pat(5, BUFB-1)));
        rd(12'h200 + 12'(BUFB-1), d);
        chk(d == 32'(rep(BUFB-1)), "R12 last response byte", d, 32'(rep(BUFB-1)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_mode0();
        t_mode3();
        t_div(7, 16);
        t_div(4, 2);
        t_div(6, 3);
        t_div(0, 1);
        t_irq();
        t_len0();
        t_force();
        t_busy_ignore();
        t_dev7();
        t_clamp();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule